// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a 34-bit physical address by reading a two-level page table out of memory. A requester presents the address together with the kind of access (instruction fetch, data load or data store), the current privilege level, four status bits and the translation base. The four status bits are: use the saved privilege for data accesses, the saved privilege itself, let the supervisor touch user pages, and let loads read execute-only pages. The translation base holds an enable bit and a root page number. The walker resolves the privilege that applies to the access and bypasses translation where none applies. Otherwise it fetches one 4-byte entry per level through a single request/response memory port, and it reports the translated address with read, write and execute permissions, or a page fault with its cause code.

When a usable leaf entry still has its accessed flag clear, or its dirty flag clear on a store, the walker writes the flags back itself. It does this with a compare-and-swap on the same memory port. If another agent changed the entry between the read and the swap, the memory reports the new value, the swap does not take effect, and the walk starts again from the root. One translation is in flight at a time, and `req_ready` is high only while the walker is idle.

Top module: `pt_walker`

## Requirements
- R1: The effective privilege is the requested privilege, except for a load or store (access code 1 or 2) requested at machine level (privilege code 3) with `st_mprv` set, which uses `st_mpp` instead. A fetch (access code 0) never takes `st_mpp`. Privilege codes: 0 user, 1 supervisor, 3 machine.
- R2: When the effective privilege is machine or `xlate_on` is 0, the result arrives in the cycle after acceptance with the virtual address zero-extended as the physical address, all three permissions set, no fault, and no memory request issued.
- R3: Entry layout: bit 0 valid, bit 1 read, bit 2 write, bit 3 execute, bit 4 user, bit 6 accessed, bit 7 dirty, bits 31:10 page number. The first entry is read at `root_ppn`*4096 + vaddr[31:22]*4. An entry that is valid with read, write and execute all clear points to the next table, whose entry is read at its page number*4096 + vaddr[21:12]*4.
- R4: A user-flagged page faults for a supervisor access while `st_sum` is 0. A page without the user flag faults for any effective privilege other than supervisor.
- R5: An entry that is not valid, or that has write set without read, faults.
- R6: A fetch needs execute. A load needs read, or execute when `st_mxr` is 1. A store needs both read and write.
- R7: A pointer entry found at the second level faults.
- R8: A fault reports cause 12 for a fetch, 13 for a load and 15 for a store, with the address and all permissions zero.
- R9: A usable leaf whose accessed flag is clear, or whose dirty flag is clear on a store, triggers one compare-and-swap. The swap compares against the value read and writes that value with accessed set, and with dirty also set on a store. A leaf that needs no change triggers no swap.
- R10: If the swap returns a value that differs from the one compared against, the walk restarts from the root and the new value of the entry decides the result.
- R11: A leaf found at the first level maps a 4 MiB region: physical address bits 33:22 come from entry bits 31:20, and bits 21:0 come from the virtual address.
- R12: Read and execute permissions follow the leaf's flags. Write permission is reported only when the leaf is writable and the access is a store or the leaf was already dirty.
- R13: `req_ready` is low from acceptance until the result, a result is given only while idle, and each memory request lasts one cycle and waits for its response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request, taken when `req_ready` is high |
| req_ready | output | 1 | Walker idle |
| req_vaddr | input | 32 | Virtual address |
| req_acc | input | 2 | Access kind: 0 fetch, 1 load, 2 store |
| req_priv | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| st_mprv | input | 1 | Data accesses at machine level use `st_mpp` |
| st_mpp | input | 2 | Saved privilege |
| st_sum | input | 1 | Supervisor may access user pages |
| st_mxr | input | 1 | Loads may read execute-only pages |
| xlate_on | input | 1 | Translation enabled |
| root_ppn | input | 22 | Page number of the first-level table |
| mem_req | output | 1 | Memory request, one cycle |
| mem_cas | output | 1 | 1: compare-and-swap, 0: read |
| mem_addr | output | 34 | Entry address |
| mem_cmp | output | 32 | Swap compare value |
| mem_wdata | output | 32 | Swap new value |
| mem_rsp_valid | input | 1 | Memory response |
| mem_rdata | input | 32 | Read data, or the prior value for a swap |
| resp_valid | output | 1 | Result valid, one cycle |
| resp_fault | output | 1 | Page fault |
| resp_cause | output | 4 | Fault cause code, 0 when no fault |
| resp_paddr | output | 34 | Physical address |
| resp_r | output | 1 | Read allowed |
| resp_w | output | 1 | Write allowed |
| resp_x | output | 1 | Execute allowed |

## Verification
The bench builds the walker with its default parameters: 32-bit virtual addresses, 4 KiB pages, two levels of 10-bit indexes and 4-byte entries. With these values a two-page memory model can hold both a root table and one second-level table. That puts every outcome in reach with a handful of entries: a superpage leaf at the first level, a pointer left over at the last level, and ordinary leaves with each permission mix. The memory model can corrupt a chosen swap to force the restart path, and it records the read and swap addresses and payloads so that the walk order and the flag write-back can be checked at the port.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2
  } acc_e;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  // entry flag positions
  localparam int FLG_V   = 0;
  localparam int FLG_R   = 1;
  localparam int FLG_W   = 2;
  localparam int FLG_X   = 3;
  localparam int FLG_U   = 4;
  localparam int FLG_A   = 6;
  localparam int FLG_D   = 7;
  localparam int PPN_LSB = 10;

  localparam logic [3:0] CAUSE_FETCH_PF = 4'd12;
  localparam logic [3:0] CAUSE_LOAD_PF  = 4'd13;
  localparam logic [3:0] CAUSE_STORE_PF = 4'd15;

  function automatic logic [3:0] pf_cause(acc_e a);
    case (a)
      ACC_FETCH: return CAUSE_FETCH_PF;
      ACC_STORE: return CAUSE_STORE_PF;
      default:   return CAUSE_LOAD_PF;
    endcase
  endfunction

endpackage

// File: rtl/ptw_mode_sel.sv
module ptw_mode_sel
  import ptw_pkg::*;
(
  input  logic [1:0] priv,
  input  acc_e       acc,
  input  logic       mprv,
  input  logic [1:0] mpp,
  input  logic       xlate_on,
  output logic [1:0] eff_priv,
  output logic       bypass
);
  always_comb begin
    eff_priv = priv;
    if (priv == PRIV_M && acc != ACC_FETCH && mprv)
      eff_priv = mpp;
    bypass = (eff_priv == PRIV_M) || !xlate_on;
  end
endmodule

// File: rtl/ptw_leaf_check.sv
module ptw_leaf_check
  import ptw_pkg::*;
#(
  parameter int PTE_W = 32
) (
  input  logic [PTE_W-1:0] pte,
  input  logic [1:0]       eff_priv,
  input  acc_e             acc,
  input  logic             sum,
  input  logic             mxr,
  output logic             is_table,
  output logic             leaf_ok,
  output logic [PTE_W-1:0] upd_pte
);
  logic v, r, w, x, u;
  logic priv_ok, shape_ok, perm_ok;

  always_comb begin
    v = pte[FLG_V];
    r = pte[FLG_R];
    w = pte[FLG_W];
    x = pte[FLG_X];
    u = pte[FLG_U];
    is_table = v && !r && !w && !x;
    priv_ok  = u ? !(eff_priv == PRIV_S && !sum) : (eff_priv == PRIV_S);
    shape_ok = v && !(w && !r);
    case (acc)
      ACC_FETCH: perm_ok = x;
      ACC_STORE: perm_ok = r && w;
      default:   perm_ok = r || (mxr && x);
    endcase
    leaf_ok = !is_table && priv_ok && shape_ok && perm_ok;
    upd_pte = pte;
    upd_pte[FLG_A] = 1'b1;
    if (acc == ACC_STORE) upd_pte[FLG_D] = 1'b1;
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int VA_W        = 32,
  parameter int PTE_W       = 32,
  parameter int PAGE_SHIFT  = 12,
  parameter int IDX_W       = 10,
  parameter int LEVELS      = 2,
  parameter int ENTRY_BYTES = 4,
  localparam int PPN_W      = PTE_W - PPN_LSB,
  localparam int PA_W       = PPN_W + PAGE_SHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [1:0]       req_acc,
  input  logic [1:0]       req_priv,
  input  logic             st_mprv,
  input  logic [1:0]       st_mpp,
  input  logic             st_sum,
  input  logic             st_mxr,
  input  logic             xlate_on,
  input  logic [PPN_W-1:0] root_ppn,
  output logic             mem_req,
  output logic             mem_cas,
  output logic [PA_W-1:0]  mem_addr,
  output logic [PTE_W-1:0] mem_cmp,
  output logic [PTE_W-1:0] mem_wdata,
  input  logic             mem_rsp_valid,
  input  logic [PTE_W-1:0] mem_rdata,
  output logic             resp_valid,
  output logic             resp_fault,
  output logic [3:0]       resp_cause,
  output logic [PA_W-1:0]  resp_paddr,
  output logic             resp_r,
  output logic             resp_w,
  output logic             resp_x
);
  localparam int LVL_W       = (LEVELS > 1) ? $clog2(LEVELS) : 1;
  localparam int ENTRY_SHIFT = $clog2(ENTRY_BYTES);
  localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(LEVELS - 1);

  typedef enum logic [2:0] {S_IDLE, S_RD, S_RDW, S_CAS, S_CASW} st_e;

  // address of the entry selected by idx in the table at base
  function automatic logic [PA_W-1:0] entry_addr(logic [PA_W-1:0] base,
                                                 logic [IDX_W-1:0] idx);
    return base + (PA_W'(idx) << ENTRY_SHIFT);
  endfunction

  // leaf address; at level lvl the low lvl*IDX_W page bits come from the VA
  function automatic logic [PA_W-1:0] leaf_addr(logic [PPN_W-1:0] ppn,
                                                logic [VA_W-1:0] va,
                                                logic [LVL_W-1:0] lvl);
    logic [PPN_W-1:0] keep, vpn, mix;
    keep = {PPN_W{1'b1}} << (int'(lvl) * IDX_W);
    vpn  = PPN_W'(va[VA_W-1:PAGE_SHIFT]);
    mix  = (ppn & keep) | (vpn & ~keep);
    return {mix, va[PAGE_SHIFT-1:0]};
  endfunction

  st_e              state;
  logic [LVL_W-1:0] lvl_q;
  logic [PA_W-1:0]  base_q;
  logic [VA_W-1:0]  va_q;
  acc_e             acc_q;
  logic [1:0]       eff_q;
  logic             sum_q, mxr_q, byp_q;
  logic [PPN_W-1:0] root_q;
  logic [PTE_W-1:0] pte_q, upd_q;

  acc_e             acc_in;
  logic [1:0]       eff_in;
  logic             byp_in;
  logic             is_table, leaf_ok;
  logic [PTE_W-1:0] upd_pte, done_pte;
  logic [IDX_W-1:0] cur_idx;

  // named events
  logic ev_accept, rsp_rd, rsp_cas;
  logic ev_descend, ev_walk_fault, ev_need_cas, ev_leaf_done;
  logic ev_cas_ok, ev_cas_fail, ev_finish;

  assign acc_in = acc_e'(req_acc);

  ptw_mode_sel u_mode (
    .priv(req_priv), .acc(acc_in), .mprv(st_mprv), .mpp(st_mpp),
    .xlate_on(xlate_on), .eff_priv(eff_in), .bypass(byp_in)
  );

  ptw_leaf_check #(.PTE_W(PTE_W)) u_chk (
    .pte(mem_rdata), .eff_priv(eff_q), .acc(acc_q), .sum(sum_q), .mxr(mxr_q),
    .is_table(is_table), .leaf_ok(leaf_ok), .upd_pte(upd_pte)
  );

  always_comb begin
    req_ready     = (state == S_IDLE);
    ev_accept     = req_ready && req_valid;
    rsp_rd        = mem_rsp_valid && (state == S_RDW);
    rsp_cas       = mem_rsp_valid && (state == S_CASW);
    ev_descend    = rsp_rd && is_table && (lvl_q != '0);
    ev_walk_fault = rsp_rd && ((is_table && lvl_q == '0) || (!is_table && !leaf_ok));
    ev_need_cas   = rsp_rd && !is_table && leaf_ok && (upd_pte != mem_rdata);
    ev_leaf_done  = rsp_rd && !is_table && leaf_ok && (upd_pte == mem_rdata);
    ev_cas_ok     = rsp_cas && (mem_rdata == pte_q);
    ev_cas_fail   = rsp_cas && (mem_rdata != pte_q);
    ev_finish     = ev_leaf_done || ev_cas_ok;
    done_pte      = ev_cas_ok ? upd_q : mem_rdata;
    cur_idx       = va_q[PAGE_SHIFT + int'(lvl_q) * IDX_W +: IDX_W];
    mem_req       = (state == S_RD) || (state == S_CAS);
    mem_cas       = (state == S_CAS);
    mem_addr      = entry_addr(base_q, cur_idx);
    mem_cmp       = pte_q;
    mem_wdata     = upd_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      lvl_q      <= '0;
      base_q     <= '0;
      va_q       <= '0;
      acc_q      <= ACC_FETCH;
      eff_q      <= PRIV_U;
      sum_q      <= 1'b0;
      mxr_q      <= 1'b0;
      byp_q      <= 1'b0;
      root_q     <= '0;
      pte_q      <= '0;
      upd_q      <= '0;
      resp_valid <= 1'b0;
      resp_fault <= 1'b0;
      resp_cause <= '0;
      resp_paddr <= '0;
      resp_r     <= 1'b0;
      resp_w     <= 1'b0;
      resp_x     <= 1'b0;
    end else begin
      resp_valid <= 1'b0;
      case (state)
        S_IDLE: if (ev_accept) begin
          va_q   <= req_vaddr;
          acc_q  <= acc_in;
          eff_q  <= eff_in;
          sum_q  <= st_sum;
          mxr_q  <= st_mxr;
          root_q <= root_ppn;
          byp_q  <= byp_in;
          if (byp_in) begin
            resp_valid <= 1'b1;
            resp_fault <= 1'b0;
            resp_cause <= '0;
            resp_paddr <= PA_W'(req_vaddr);
            resp_r     <= 1'b1;
            resp_w     <= 1'b1;
            resp_x     <= 1'b1;
          end else begin
            base_q <= {root_ppn, {PAGE_SHIFT{1'b0}}};
            lvl_q  <= TOP_LVL;
            state  <= S_RD;
          end
        end
        S_RD:  state <= S_RDW;
        S_CAS: state <= S_CASW;
        S_RDW: begin
          if (ev_descend) begin
            base_q <= {mem_rdata[PTE_W-1:PPN_LSB], {PAGE_SHIFT{1'b0}}};
            lvl_q  <= lvl_q - 1'b1;
            state  <= S_RD;
          end else if (ev_walk_fault) begin
            resp_valid <= 1'b1;
            resp_fault <= 1'b1;
            resp_cause <= pf_cause(acc_q);
            resp_paddr <= '0;
            resp_r     <= 1'b0;
            resp_w     <= 1'b0;
            resp_x     <= 1'b0;
            state      <= S_IDLE;
          end else if (ev_need_cas) begin
            pte_q <= mem_rdata;
            upd_q <= upd_pte;
            state <= S_CAS;
          end
        end
        S_CASW: if (ev_cas_fail) begin
          base_q <= {root_q, {PAGE_SHIFT{1'b0}}};
          lvl_q  <= TOP_LVL;
          state  <= S_RD;
        end
        default: state <= S_IDLE;
      endcase
      if (ev_finish) begin
        resp_valid <= 1'b1;
        resp_fault <= 1'b0;
        resp_cause <= '0;
        resp_paddr <= leaf_addr(done_pte[PTE_W-1:PPN_LSB], va_q, lvl_q);
        resp_r     <= done_pte[FLG_R];
        resp_x     <= done_pte[FLG_X];
        resp_w     <= done_pte[FLG_W] && (acc_q == ACC_STORE || done_pte[FLG_D]);
        state      <= S_IDLE;
      end
    end
  end

  // ---------------- assertions ----------------
  AST_BYPASS_IDENTITY: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && byp_q |-> resp_paddr == PA_W'(va_q) && resp_r && resp_w && resp_x && !resp_fault); // R2

  AST_FAULT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_fault |-> resp_paddr == '0 && !resp_r && !resp_w && !resp_x &&
      (resp_cause == 4'd12 || resp_cause == 4'd13 || resp_cause == 4'd15)); // R8

  AST_STORE_FAULT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_fault && acc_q == ACC_STORE |-> resp_cause == 4'd15); // R8

  AST_SWAP_SETS_ACCESSED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_cas |-> mem_wdata[FLG_A] && (mem_wdata != mem_cmp)); // R9

  AST_ONE_CYCLE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req); // R13

  AST_RESULT_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> req_ready); // R13

endmodule

// File: tb/pt_walker_bench.sv
module pt_walker_bench;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_acc = '0, req_priv = '0, st_mpp = '0;
  logic        st_mprv = 1'b0, st_sum = 1'b0, st_mxr = 1'b0, xlate_on = 1'b0;
  logic [21:0] root_ppn = '0;
  logic        mem_req, mem_cas;
  logic [33:0] mem_addr;
  logic [31:0] mem_cmp, mem_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        resp_valid, resp_fault, resp_r, resp_w, resp_x;
  logic [3:0]  resp_cause;
  logic [33:0] resp_paddr;

  always #2 clk = ~clk;

  pt_walker u_pt_walker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_acc(req_acc), .req_priv(req_priv),
    .st_mprv(st_mprv), .st_mpp(st_mpp), .st_sum(st_sum), .st_mxr(st_mxr),
    .xlate_on(xlate_on), .root_ppn(root_ppn),
    .mem_req(mem_req), .mem_cas(mem_cas), .mem_addr(mem_addr),
    .mem_cmp(mem_cmp), .mem_wdata(mem_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rdata(mem_rdata),
    .resp_valid(resp_valid), .resp_fault(resp_fault), .resp_cause(resp_cause),
    .resp_paddr(resp_paddr), .resp_r(resp_r), .resp_w(resp_w), .resp_x(resp_x)
  );

  // ---------------- memory model: two 4 KiB pages ----------------
  logic [31:0] mem [2048];
  int          rd_cnt = 0, cas_cnt = 0, meddle_at = -1;
  logic [33:0] last_rd = '0, prev_rd = '0;
  logic [31:0] last_cmp = '0, last_wdata = '0, cur;

  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (mem_req) begin
      mem_rsp_valid <= 1'b1;
      if (mem_cas) begin
        cur = mem[mem_addr[12:2]];
        if (cas_cnt == meddle_at) begin
          cur = cur | 32'h20;
          mem[mem_addr[12:2]] = cur;
        end
        mem_rdata <= cur;
        if (cur == mem_cmp) mem[mem_addr[12:2]] = mem_wdata;
        last_cmp   <= mem_cmp;
        last_wdata <= mem_wdata;
        cas_cnt    = cas_cnt + 1;
      end else begin
        mem_rdata <= mem[mem_addr[12:2]];
        prev_rd   <= last_rd;
        last_rd   <= mem_addr;
        rd_cnt    = rd_cnt + 1;
      end
    end
  end

  task automatic init_mem();
    for (int i = 0; i < 2048; i++) mem[i] = '0;
    mem[0]    = 32'h0000_0401;   // root 0 -> table page 1
    mem[1]    = 32'h0030_00CF;   // root 1: superpage, RWX, A, D
    mem[2]    = 32'h0000_0401;
    mem[1024] = 32'h048D_14C7;   // RW A D, ppn 0x12345
    mem[1025] = 32'h002A_F05B;   // user R X A, ppn 0xABC
    mem[1026] = 32'h0FFF_FC07;   // RW, A and D clear
    mem[1027] = 32'h0000_0405;   // W without R
    mem[1028] = 32'h0000_0401;   // pointer at last level
    mem[1029] = 32'h0000_8849;   // X only, A
    mem[1030] = 32'h0000_CC47;   // RW A, D clear
  endtask

  // ---------------- vector table ----------------
  typedef struct packed {
    logic [31:0] va;
    logic [1:0]  acc, priv;
    logic        mprv;
    logic [1:0]  mpp;
    logic        sum, mxr, on, fault;
    logic [3:0]  cause;
    logic [33:0] pa;
    logic [2:0]  rwx;
    logic [3:0]  nrd, ncas;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VECS [NV] = '{
    '{32'h00000ABC, 2'd1, 2'd1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0,  34'h012345ABC, 3'b110, 4'd2, 4'd0}, // R6 R12
    '{32'h00000ABC, 2'd2, 2'd1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0,  34'h012345ABC, 3'b110, 4'd2, 4'd0}, // R9 no swap
    '{32'h00000010, 2'd0, 2'd1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd12, 34'h0,         3'b000, 4'd2, 4'd0}, // R6 R8
    '{32'h00001004, 2'd1, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0,  34'h000ABC004, 3'b101, 4'd2, 4'd0}, // R4
    '{32'h00001004, 2'd1, 2'd1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd13, 34'h0,         3'b000, 4'd2, 4'd0}, // R4
    '{32'h00001004, 2'd1, 2'd1, 1'b0, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd0,  34'h000ABC004, 3'b101, 4'd2, 4'd0}, // R4
    '{32'h00000ABC, 2'd1, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd13, 34'h0,         3'b000, 4'd2, 4'd0}, // R4
    '{32'h00003000, 2'd1, 2'd1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd13, 34'h0,         3'b000, 4'd2, 4'd0}, // R5
    '{32'h00C00000, 2'd1, 2'd1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd13, 34'h0,         3'b000, 4'd1, 4'd0}, // R5
    '{32'h00004000, 2'd2, 2'd1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd15, 34'h0,         3'b000, 4'd2, 4'd0}, // R7
    '{32'h00005008, 2'd1, 2'd1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd13, 34'h0,         3'b000, 4'd2, 4'd0}, // R6
    '{32'h00005008, 2'd1, 2'd1, 1'b0, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 4'd0,  34'h000022008, 3'b001, 4'd2, 4'd0}, // R6
    '{32'h00005008, 2'd0, 2'd1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0,  34'h000022008, 3'b001, 4'd2, 4'd0}, // R6
    '{32'h00005008, 2'd2, 2'd1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd15, 34'h0,         3'b000, 4'd2, 4'd0}, // R6 R8
    '{32'h00523456, 2'd1, 2'd1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0,  34'h000D23456, 3'b111, 4'd1, 4'd0}, // R11
    '{32'h00000ABC, 2'd1, 2'd3, 1'b1, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0,  34'h012345ABC, 3'b110, 4'd2, 4'd0}, // R1
    '{32'h00000ABC, 2'd0, 2'd3, 1'b1, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0,  34'h000000ABC, 3'b111, 4'd0, 4'd0}, // R1 R2
    '{32'hDEADBEEF, 2'd1, 2'd3, 1'b0, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0,  34'h0DEADBEEF, 3'b111, 4'd0, 4'd0}, // R2
    '{32'h89ABCDEF, 2'd2, 2'd1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0,  34'h089ABCDEF, 3'b111, 4'd0, 4'd0}, // R2
    '{32'h00001004, 2'd1, 2'd3, 1'b1, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0,  34'h000ABC004, 3'b101, 4'd2, 4'd0}, // R1
    '{32'h00006000, 2'd1, 2'd1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0,  34'h000033000, 3'b100, 4'd2, 4'd0}, // R12
    '{32'h00006000, 2'd2, 2'd1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0,  34'h000033000, 3'b110, 4'd2, 4'd1}, // R9 R12
    '{32'h00002000, 2'd1, 2'd1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0,  34'h03FFFF000, 3'b100, 4'd2, 4'd1}  // R9
  };

  int checks = 0, errors = 0;
  logic        got_fault, ready_after, got_any;
  logic [3:0]  got_cause;
  logic [33:0] got_pa;
  logic [2:0]  got_rwx;
  int          got_rd, got_cas;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic run(input vec_t v);
    int rd0, cas0;
    logic first;
    @(negedge clk);
    req_vaddr = v.va; req_acc = v.acc; req_priv = v.priv; st_mprv = v.mprv;
    st_mpp = v.mpp; st_sum = v.sum; st_mxr = v.mxr; xlate_on = v.on;
    root_ppn = 22'd0; req_valid = 1'b1;
    rd0 = rd_cnt; cas0 = cas_cnt;
    @(posedge clk);
    #1 req_valid = 1'b0;
    first = 1'b1; got_any = 1'b0;
    for (int t = 0; t < 200; t++) begin
      @(negedge clk);
      if (first) ready_after = req_ready;
      first = 1'b0;
      if (resp_valid) begin
        got_any = 1'b1; got_fault = resp_fault; got_cause = resp_cause;
        got_pa = resp_paddr; got_rwx = {resp_r, resp_w, resp_x};
        break;
      end
    end
    got_rd = rd_cnt - rd0; got_cas = cas_cnt - cas0;
    if (!got_any) begin
      checks++; errors++;
      $display("FAIL R13 no result act=0 exp=1");
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=hung exp=done");
    summary();
    $finish;
  end

  initial begin
    init_mem();
    repeat (3) @(negedge clk);
    // reset state, R13
    chk("R13 reset ready", {63'd0, req_ready}, 64'd1);
    chk("R13 reset resp_valid", {63'd0, resp_valid}, 64'd0);
    chk("R13 reset mem_req", {63'd0, mem_req}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // table-driven vectors
    for (int i = 0; i < NV; i++) begin
      init_mem();
      run(VECS[i]);
      chk($sformatf("vec%0d fault (R8)", i), 64'(got_fault), 64'(VECS[i].fault));
      chk($sformatf("vec%0d cause (R8)", i), 64'(got_cause), 64'(VECS[i].cause));
      chk($sformatf("vec%0d paddr (R3 R11)", i), 64'(got_pa), 64'(VECS[i].pa));
      chk($sformatf("vec%0d rwx (R6 R12)", i), 64'(got_rwx), 64'(VECS[i].rwx));
      chk($sformatf("vec%0d reads (R2 R3)", i), 64'(got_rd), 64'(VECS[i].nrd));
      chk($sformatf("vec%0d swaps (R9)", i), 64'(got_cas), 64'(VECS[i].ncas));
    end

    // R3: entry addresses of a two-level walk, and busy while walking (R13)
    init_mem();
    run(VECS[3]);
    chk("R3 first entry addr", 64'(prev_rd), 64'h0);
    chk("R3 second entry addr", 64'(last_rd), 64'h1004);
    chk("R13 busy during walk", 64'(ready_after), 64'd0);
    // R3: root index taken from va[31:22]
    run(VECS[14]);
    chk("R3 root index addr", 64'(last_rd), 64'h4);

    // R9: swap payload and memory contents
    init_mem();
    run(VECS[22]);
    chk("R9 swap compare", 64'(last_cmp), 64'h0FFFFC07);
    chk("R9 swap data", 64'(last_wdata), 64'h0FFFFC47);
    chk("R9 memory after", 64'(mem[1026]), 64'h0FFFFC47);
    init_mem();
    run(VECS[21]);
    chk("R9 store sets dirty", 64'(mem[1030]), 64'h0000CCC7);

    // R10: swap loses to a concurrent change, walk restarts from the root
    init_mem();
    meddle_at = cas_cnt;
    run(VECS[21]);
    meddle_at = -1;
    chk("R10 reads after restart", 64'(got_rd), 64'd4);
    chk("R10 swaps", 64'(got_cas), 64'd2);
    chk("R10 result paddr", 64'(got_pa), 64'h33000);
    chk("R10 result rwx", 64'(got_rwx), 64'b110);
    chk("R10 memory final", 64'(mem[1030]), 64'h0000CCE7);

    // R12: after a store set dirty, a load now gets write permission
    run(VECS[20]);
    chk("R12 load on dirty page rwx", 64'(got_rwx), 64'b110);

    summary();
    $finish;
  end
endmodule